// File: doc/BRIEF.md
# Scan-Decimating Sample Stream Filter

This block sits between a sample buffer and a downstream sink. The converter is paced by a single conversion-rate timer, so scans of N channels arrive back to back with no gap between them. To get a slower effective scan rate, the block forwards one scan and then drops the next D scans. It repeats this pattern over groups of N·(1+D) samples. The drop step depends on the sample's position in the group, not on a fixed every-k-th pattern. A kept run is N contiguous samples, and it is followed by N·D discarded samples.

Input arrives in bursts of any length, with idle cycles between them. The position in the group carries across those gaps. A synchronous restart arms a new acquisition: it latches N and D, sets the position to the start of a group, and drops any kept sample that has not yet been delivered. Discarded samples are consumed at one per cycle even while the sink stalls. Kept samples wait in a one-entry output register until the sink takes them. A side-band flag marks the last kept sample of each group, so the sink can count finished scans.

Top module: `scan_dec`

## Requirements
- R1: After reset the output is empty and input ready is high. The configuration defaults to a scan length of 1 with a skip count of 0, so every sample passes until the first restart.
- R2: With latched scan length N and skip count D, sample k after a restart is forwarded exactly when (k mod N·(1+D)) < N. Forwarded samples keep their data and their order, and all other samples are consumed and dropped.
- R3: With D = 0 every accepted sample is forwarded unchanged and in order.
- R4: The group position depends only on the number of samples accepted. Idle input cycles between bursts do not change it.
- R5: When the next input position is a discard position, input ready is high even if the output holds an unaccepted sample and output ready is low.
- R6: A forwarded sample stays on the output, with data and last flag stable, until output ready is seen high. No sample is duplicated or lost.
- R7: The last flag is 1 on a forwarded sample exactly when its position in the group is N−1.
- R8: N and D are sampled only in a cycle with restart high. Changes at other times have no effect until the next restart.
- R9: While restart is high, input ready is low. In the following cycle the output is empty and the next accepted sample is position 0.
- R10: A scan length of 0 is treated as 1, and a scan length above MAX_CH (16) is treated as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous arm: latch configuration, clear position, flush output |
| scan_len_i | input | CH_W (5) | Scan length N, sampled on restart |
| skip_cnt_i | input | SKIP_W (8) | Number of scans D dropped after each kept scan, sampled on restart |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample accepted when high together with valid |
| in_data_i | input | DATA_W (16) | Input sample |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Sink accepts output sample |
| out_data_o | output | DATA_W (16) | Forwarded sample |
| out_last_o | output | 1 | Forwarded sample is the last kept one of its group |

## Verification
The assertions check on every cycle that input is blocked during restart and that the output is empty after it. They also check that a stalled output holds its data and flag, that a taken output with nothing new behind it goes empty, and that the output only becomes valid after an input was offered. Which positions are kept, where the last flag falls, the carry of position across bursts and idle gaps, the clamping of N, and the fact that mid-run configuration changes are ignored can only be shown by the bench scenarios. These compare the full output sequence against a position model for several N, D, gap and stall patterns.

// File: rtl/scan_dec_pkg.sv
package scan_dec_pkg;

  typedef struct packed {
    logic keep;
    logic last;
  } pos_dec_t;

endpackage

// File: rtl/scan_dec_pos.sv
module scan_dec_pos
  import scan_dec_pkg::*;
#(
  parameter int MAX_CH = 16,
  parameter int CH_W   = $clog2(MAX_CH + 1),
  parameter int SKIP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CH_W-1:0]   len_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic              advance_i,
  output pos_dec_t          dec_o
);

  localparam logic [CH_W-1:0] LEN_MAX = CH_W'(MAX_CH);
  localparam logic [CH_W-1:0] LEN_ONE = CH_W'(1);

  logic [CH_W-1:0]   len_q, len_clamped, chan_q;
  logic [SKIP_W-1:0] skip_q, scan_q;
  logic              chan_wrap;

  always_comb begin
    if (len_i == '0)          len_clamped = LEN_ONE;
    else if (len_i > LEN_MAX) len_clamped = LEN_MAX;
    else                      len_clamped = len_i;
  end

  assign chan_wrap = (chan_q == len_q - LEN_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= LEN_ONE;
      skip_q <= '0;
      chan_q <= '0;
      scan_q <= '0;
    end else if (restart_i) begin
      len_q  <= len_clamped;
      skip_q <= skip_i;
      chan_q <= '0;
      scan_q <= '0;
    end else if (advance_i) begin
      if (chan_wrap) begin
        chan_q <= '0;
        scan_q <= (scan_q == skip_q) ? '0 : scan_q + SKIP_W'(1);
      end else begin
        chan_q <= chan_q + LEN_ONE;
      end
    end
  end

  assign dec_o.keep = (scan_q == '0);
  assign dec_o.last = (scan_q == '0) && chan_wrap;

endmodule

// File: rtl/scan_dec_hold.sv
module scan_dec_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_o
);

  logic              valid_q, last_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      if (flush_i)      valid_q <= 1'b0;
      else if (load_i)  valid_q <= 1'b1;
      else if (ready_i) valid_q <= 1'b0;
      if (load_i) begin
        data_q <= data_i;
        last_q <= last_i;
      end
    end
  end

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;

endmodule

// File: rtl/scan_dec.sv
module scan_dec
  import scan_dec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_CH = 16,
  parameter int CH_W   = $clog2(MAX_CH + 1),
  parameter int SKIP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [CH_W-1:0]   scan_len_i,
  input  logic [SKIP_W-1:0] skip_cnt_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);

  pos_dec_t dec;
  logic     hold_free, in_fire, load;

  // drop positions never wait on the sink
  assign in_ready_o = !restart_i && (!dec.keep || hold_free);
  assign in_fire    = in_valid_i && in_ready_o;
  assign load       = in_fire && dec.keep;

  scan_dec_pos #(
    .MAX_CH(MAX_CH), .CH_W(CH_W), .SKIP_W(SKIP_W)
  ) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_i),
    .len_i     (scan_len_i),
    .skip_i    (skip_cnt_i),
    .advance_i (in_fire),
    .dec_o     (dec)
  );

  scan_dec_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (restart_i),
    .load_i  (load),
    .data_i  (in_data_i),
    .last_i  (dec.last),
    .ready_i (out_ready_i),
    .free_o  (hold_free),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .last_o  (out_last_o)
  );

endmodule

// File: rtl/scan_dec_chk.sv
module scan_dec_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              restart_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_last_o
);

  AST_RESTART_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !in_ready_o); // R9

  AST_RESTART_FLUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !out_valid_o); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !restart_i
      |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R6

  AST_NO_DUPLICATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R6

  AST_OUTPUT_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i)); // R2

endmodule

bind scan_dec scan_dec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .restart_i   (restart_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/scan_dec_tb.sv
module scan_dec_tb;

  localparam int DATA_W = 16;
  localparam int MAX_CH = 16;
  localparam int CH_W   = 5;
  localparam int SKIP_W = 8;
  localparam int NVEC   = 8;

  // n, d, len, gap, stall, expected kept count
  localparam int VEC [NVEC][6] = '{
    '{1,  0, 20, 0, 0, 20},  // R3 pass-through
    '{3,  2, 40, 1, 1, 15},  // R2 R4 R6
    '{16, 1, 70, 0, 1, 38},  // R2 full width
    '{4,  3, 50, 1, 0, 14},  // R4 gaps
    '{2,  0, 17, 0, 1, 17},  // R3 R7
    '{5,  7, 45, 1, 1, 10},  // R2 long skip
    '{0,  1, 4,  0, 0, 2},   // R10 zero length -> 1
    '{31, 1, 20, 0, 0, 16}   // R10 over max -> 16
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              restart_i = 1'b0;
  logic [CH_W-1:0]   scan_len_i = '0;
  logic [SKIP_W-1:0] skip_cnt_i = '0;
  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b0;
  logic [DATA_W-1:0] out_data_o;
  logic              out_last_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  scan_dec #(.DATA_W(DATA_W), .MAX_CH(MAX_CH), .CH_W(CH_W), .SKIP_W(SKIP_W)) u_dut (
    .clk_i, .rst_ni, .restart_i, .scan_len_i, .skip_cnt_i,
    .in_valid_i, .in_ready_o, .in_data_i,
    .out_valid_o, .out_ready_i, .out_data_o, .out_last_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clamp_len(input int n);
    if (n == 0) return 1;
    if (n > MAX_CH) return MAX_CH;
    return n;
  endfunction

  // called at a negedge; R8: config inputs are scrambled after the restart cycle
  task automatic do_restart(input int n, input int d);
    restart_i  = 1'b1;
    scan_len_i = CH_W'(n);
    skip_cnt_i = SKIP_W'(d);
    in_valid_i = 1'b0;
    #1;
    chk(in_ready_o == 1'b0, "R9 ready during restart", int'(in_ready_o), 0);
    @(negedge clk_i);
    restart_i  = 1'b0;
    scan_len_i = CH_W'(7);
    skip_cnt_i = '0;
  endtask

  task automatic stream(input int n, input int d, input int len, input bit gap,
                        input bit stall, input int exp_cnt, input int base, input string tag);
    int ne, grp, sent, got, idx, cyc, pos;
    ne = clamp_len(n);
    grp = ne * (d + 1);
    sent = 0; got = 0; idx = 0; cyc = 0;
    while ((sent < len || out_valid_o) && cyc < 4000) begin
      in_valid_i  = (sent < len) && !(gap && (cyc % 3 == 2));
      in_data_i   = DATA_W'(base + sent);
      out_ready_i = !(stall && (cyc % 4 < 2));
      #1;
      if (out_valid_o && out_ready_i) begin
        while ((idx % grp) >= ne) idx++;
        pos = idx % grp;
        chk(out_data_o == DATA_W'(base + idx), "R2 data", int'(out_data_o), base + idx);
        chk(out_last_o == (pos == ne - 1), "R7 last flag", int'(out_last_o), int'(pos == ne - 1));
        idx++;
        got++;
      end
      if (in_valid_i && in_ready_o) sent++;
      @(negedge clk_i);
      cyc++;
    end
    in_valid_i  = 1'b0;
    out_ready_i = 1'b0;
    chk(got == exp_cnt, tag, got, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(out_valid_o == 1'b0, "R1 out empty in reset", int'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(in_ready_o == 1'b1, "R1 ready after reset", int'(in_ready_o), 1);
    @(negedge clk_i);
    // R1: default config passes everything before any restart
    stream(1, 0, 3, 0, 0, 3, 16'h0100, "R1 default pass count");

    for (int v = 0; v < NVEC; v++) begin
      do_restart(VEC[v][0], VEC[v][1]);
      stream(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3] != 0, VEC[v][4] != 0,
             VEC[v][5], (v + 2) << 12, "R2 kept count");
    end

    // R5 R6: discard accepted under stall, kept sample held
    do_restart(1, 1);
    out_ready_i = 1'b0;
    in_valid_i = 1'b1; in_data_i = 16'h0011;
    #1 chk(in_ready_o == 1'b1, "R5 keep accepted into empty reg", int'(in_ready_o), 1);
    @(negedge clk_i);
    in_data_i = 16'h0022;
    #1 chk(in_ready_o == 1'b1, "R5 discard under stall", int'(in_ready_o), 1);
    chk(out_valid_o == 1'b1, "R6 held valid", int'(out_valid_o), 1);
    @(negedge clk_i);
    in_data_i = 16'h0033;
    #1 chk(in_ready_o == 1'b0, "R6 keep blocked by full reg", int'(in_ready_o), 0);
    chk(out_data_o == 16'h0011, "R6 held data", int'(out_data_o), 16'h0011);
    @(negedge clk_i);
    chk(out_data_o == 16'h0011, "R6 still held", int'(out_data_o), 16'h0011);
    out_ready_i = 1'b1;
    #1 chk(in_ready_o == 1'b1, "R6 ready when draining", int'(in_ready_o), 1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1 chk(out_data_o == 16'h0033 && out_last_o, "R7 next kept with last", int'(out_data_o), 16'h0033);
    @(negedge clk_i);
    #1 chk(out_valid_o == 1'b0, "R6 no duplicate", int'(out_valid_o), 0);

    // R9: restart flushes a pending sample
    out_ready_i = 1'b0;
    in_valid_i = 1'b1; in_data_i = 16'h0044; // discard position
    @(negedge clk_i);
    in_data_i = 16'h0055;                   // kept, stays pending
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1 chk(out_valid_o == 1'b1, "R9 pending before restart", int'(out_valid_o), 1);
    @(negedge clk_i);
    do_restart(2, 1);
    #1 chk(out_valid_o == 1'b0, "R9 flushed after restart", int'(out_valid_o), 0);
    stream(2, 1, 8, 0, 0, 4, 16'h0600, "R9 position zero after restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule